// File: doc/BRIEF.md
# Byte-Register SPI Master

This block is a memory-mapped SPI master for an 8-bit register bus. Software programs a mode byte, a clock-divider byte and the direction and level of the slave-select pin, then writes a byte to the data register. The block shifts that byte out on MOSI while it shifts one in from MISO, and it drives a serial clock whose polarity, phase, bit order and rate all come from those registers.

When a byte completes, the received value is held in the data register and a completion flag is raised. A write made while a shift is still running does not start anything: it sets a collision flag and the byte is lost. When the block is an enabled master and the slave-select pin is left as an input that something outside pulls low, a mode-fault flag is set and any running shift stops. Each flag clears only through a read of the status register followed by a read of the data register. Two interrupt lines report completion and mode fault.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, control-1 (offset 0x00), control-2 (0x01), baud (0x04), status (0x05) and port direction (0x10) read 0, port data (0x0D) reads 0x08, SCK is 0, ss_out_n is 1 and ss_oe is 0.
- R2: When control-1 bit 6 (enable) and bit 4 (master) are both 1 and no shift is running, a write to data (0x09) starts an 8-bit exchange. At the end, status bit 7 is 1 and reading data returns the byte sampled from MISO.
- R3: SCK rests at the level of control-1 bit 3 whenever no shift is running, and it returns to that level after the 16th edge.
- R4: With control-1 bit 2 at 0, each MOSI bit is valid before the first edge of its pair and is sampled on that edge. With bit 2 at 1, MOSI changes on the first edge of each pair and data is sampled on the second.
- R5: With control-1 bit 0 at 1, bit 0 goes first on MOSI and the first MISO bit becomes bit 0 of the received byte. With bit 0 at 0, bit 7 goes first.
- R6: One SCK period lasts (P+1)·2^(E+1) clock cycles, where P is baud bits 6:4 and E is baud bits 2:0.
- R7: A write to data while a shift is running sets status bit 6. It leaves the running byte and its MOSI stream unchanged and does not queue the written byte.
- R8: Status bits 7, 6 and 4 clear only when a status read that sees a flag set is followed by a data read. A data read without that earlier status read clears nothing.
- R9: When the block is an enabled master, port-direction bit 3 is 0 and ss_in_n is low, status bit 4 is set.
- R10: irq_done equals control-1 bit 7 AND status bit 7. irq_fault equals control-1 bit 7 AND status bit 4.
- R11: ss_out_n follows port-data bit 3 and ss_oe follows port-direction bit 3. Writing 0x0E to port direction turns the SS driver on.
- R12: A data write while either the enable bit or the master bit is 0 starts no shift, leaves SCK still and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| irq_done | output | 1 | Transfer-complete interrupt |
| irq_fault | output | 1 | Mode-fault interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_out_n | output | 1 | Slave-select level to drive |
| ss_oe | output | 1 | Slave-select driver enable |
| ss_in_n | input | 1 | Slave-select pin level seen from outside |

## Verification
On every cycle, the assertions check these properties:
- SCK rests at its polarity level whenever the shifter is idle.
- The divider counter stays below its half-period limit.
- A data write while a shift is running always sets the collision flag on the next edge.
- A mode-fault condition always sets the fault flag.
- The completion flag rises only on a completion pulse.
- A qualified status-then-data read clears the completion flag.

Only the bench scenarios can show the rest:
- That each polarity, phase and bit-order setting moves the correct bits on MOSI and assembles the correct received byte.
- That the measured SCK period matches the baud field.
- That a colliding byte never reaches the wire.
- That a data read without a preceding status read leaves the flags set.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE2  = 5'h01;
  localparam logic [ADDR_W-1:0] OFS_RATE   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h05;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h09;
  localparam logic [ADDR_W-1:0] OFS_PIN    = 5'h0D;
  localparam logic [ADDR_W-1:0] OFS_PINDIR = 5'h10;

  // mode byte fields in bit order 7..0 (bit 5 reads as zero)
  typedef struct packed {
    logic irq_en;
    logic sys_en;
    logic spare;
    logic master;
    logic pol;
    logic pha;
    logic ss_drv;
    logic lsb_first;
  } mode_t;
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter int PRE_W = 3,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  localparam int CNT_W = PRE_W + (1 << EXP_W);

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign half = (CNT_W'(pre) + CNT_W'(1)) << expo;
  assign wrap = (cnt_q == half - CNT_W'(1));
  assign tick = run & wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              pol,
  input  logic              pha,
  input  logic              lsb_first,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int EDGES = 2 * DATA_W;
  localparam int ECW   = $clog2(EDGES);
  localparam int IDXW  = $clog2(DATA_W);

  logic              busy_q, busy_d;
  logic [ECW-1:0]    edge_q, edge_d;
  logic              ph_q, ph_d;
  logic              mosi_q, mosi_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              first_half, samp, shft, last_edge;
  logic [IDXW-1:0]   pair;
  logic [DATA_W-1:0] rx_next;

  function automatic logic pick(input logic [DATA_W-1:0] b, input logic [IDXW-1:0] i,
                                input logic lsb);
    return lsb ? b[i] : b[DATA_W-1-int'(i)];
  endfunction

  assign first_half = ~edge_q[0];
  assign pair       = edge_q[ECW-1:1];
  assign samp       = busy_q & tick & (pha ? ~first_half : first_half);
  assign shft       = busy_q & tick & (pha ? first_half : ~first_half);
  assign last_edge  = (edge_q == ECW'(EDGES - 1));
  assign rx_next    = lsb_first ? {miso, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], miso};

  always_comb begin
    busy_d = busy_q;
    edge_d = edge_q;
    ph_d   = ph_q;
    mosi_d = mosi_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      edge_d = '0;
      ph_d   = 1'b0;
      tx_d   = tx_byte;
      rx_d   = '0;
      if (!pha) mosi_d = pick(tx_byte, '0, lsb_first);
    end else if (busy_q) begin
      if (abort) begin
        busy_d = 1'b0;
        ph_d   = 1'b0;
      end else if (tick) begin
        ph_d   = ~ph_q;
        edge_d = edge_q + ECW'(1);
        if (samp) rx_d = rx_next;
        if (shft) begin
          if (pha)                           mosi_d = pick(tx_q, pair, lsb_first);
          else if (pair != IDXW'(DATA_W-1))  mosi_d = pick(tx_q, pair + IDXW'(1), lsb_first);
        end
        if (last_edge) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      ph_q   <= 1'b0;
      mosi_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      edge_q <= edge_d;
      ph_q   <= ph_d;
      mosi_q <= mosi_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign sck     = pol ^ ph_q;
  assign mosi    = mosi_q;
  assign done    = busy_q & ~abort & tick & last_edge;
  assign rx_byte = samp ? rx_next : rx_q;

  a_r3_sck_rests: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (sck == pol));
  a_r2_done_ends_shift: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: rtl/spi_reg_block.sv
module spi_reg_block
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              ss_in_n,
  output mode_t             mode,
  output logic [2:0]        pre,
  output logic [2:0]        expo,
  output logic              start,
  output logic              abort,
  output logic              irq_done,
  output logic              irq_fault,
  output logic              ss_out_n,
  output logic              ss_oe
);
  localparam int SS_BIT = 3;

  mode_t             mode_q, mode_d;
  logic [DATA_W-1:0] mode2_q, mode2_d;
  logic [DATA_W-1:0] rate_q, rate_d;
  logic [DATA_W-1:0] pin_q, pin_d;
  logic [DATA_W-1:0] dir_q, dir_d;
  logic [DATA_W-1:0] rxbuf_q, rxbuf_d;
  logic              cmpl_q, cmpl_d, coll_q, coll_d, flt_q, flt_d, arm_q, arm_d;
  logic              wr_hit, rd_stat, rd_data, wr_data, master_on, coll_set, flt_set, clr;

  assign wr_hit    = bus_sel & bus_wr;
  assign wr_data   = wr_hit & (bus_addr == OFS_DATA);
  assign rd_stat   = bus_sel & bus_rd & (bus_addr == OFS_STAT);
  assign rd_data   = bus_sel & bus_rd & (bus_addr == OFS_DATA);
  assign master_on = mode_q.sys_en & mode_q.master;
  assign start     = wr_data & master_on & ~busy;
  assign coll_set  = wr_data & master_on & busy;
  assign flt_set   = master_on & ~dir_q[SS_BIT] & ~ss_in_n;
  assign abort     = flt_set | ~master_on;
  assign clr       = rd_data & arm_q;

  always_comb begin
    mode_d  = mode_q;
    mode2_d = mode2_q;
    rate_d  = rate_q;
    pin_d   = pin_q;
    dir_d   = dir_q;
    if (wr_hit) begin
      unique case (bus_addr)
        OFS_MODE:   mode_d  = mode_t'(bus_wdata & 8'hDF);
        OFS_MODE2:  mode2_d = bus_wdata;
        OFS_RATE:   rate_d  = bus_wdata & 8'h77;
        OFS_PIN:    pin_d   = bus_wdata;
        OFS_PINDIR: dir_d   = bus_wdata;
        default: ;
      endcase
    end
    rxbuf_d = done ? rx_byte : rxbuf_q;
    cmpl_d  = done     | (cmpl_q & ~clr);
    coll_d  = coll_set | (coll_q & ~clr);
    flt_d   = flt_set  | (flt_q  & ~clr);
    arm_d   = arm_q;
    if (rd_stat && (cmpl_q || coll_q || flt_q)) arm_d = 1'b1;
    if (rd_data)                                 arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      mode2_q <= '0;
      rate_q  <= '0;
      pin_q   <= 8'h08;
      dir_q   <= '0;
      rxbuf_q <= '0;
      cmpl_q  <= 1'b0;
      coll_q  <= 1'b0;
      flt_q   <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      mode2_q <= mode2_d;
      rate_q  <= rate_d;
      pin_q   <= pin_d;
      dir_q   <= dir_d;
      rxbuf_q <= rxbuf_d;
      cmpl_q  <= cmpl_d;
      coll_q  <= coll_d;
      flt_q   <= flt_d;
      arm_q   <= arm_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && bus_rd) begin
      unique case (bus_addr)
        OFS_MODE:   bus_rdata = mode_q;
        OFS_MODE2:  bus_rdata = mode2_q;
        OFS_RATE:   bus_rdata = rate_q;
        OFS_STAT:   bus_rdata = {cmpl_q, coll_q, 1'b0, flt_q, 4'b0000};
        OFS_DATA:   bus_rdata = rxbuf_q;
        OFS_PIN:    bus_rdata = pin_q;
        OFS_PINDIR: bus_rdata = dir_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign mode      = mode_q;
  assign pre       = rate_q[6:4];
  assign expo      = rate_q[2:0];
  assign irq_done  = mode_q.irq_en & cmpl_q;
  assign irq_fault = mode_q.irq_en & flt_q;
  assign ss_out_n  = pin_q[SS_BIT];
  assign ss_oe     = dir_q[SS_BIT];

  a_r7_collision_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && master_on && busy) |=> coll_q);
  a_r9_fault_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (master_on && !dir_q[SS_BIT] && !ss_in_n) |=> flt_q);
  a_r2_flag_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpl_q) |-> $past(done));
  a_r8_qualified_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && arm_q && !done) |=> !cmpl_q);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_done,
  output logic              irq_fault,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_out_n,
  output logic              ss_oe,
  input  logic              ss_in_n
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  mode_t             mode;
  logic [2:0]        pre, expo;
  logic              start, abort, busy, done, tick;
  logic [DATA_W-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  spi_reg_block #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(core_rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .rx_byte(rx_byte), .ss_in_n(ss_in_n),
    .mode(mode), .pre(pre), .expo(expo), .start(start), .abort(abort),
    .irq_done(irq_done), .irq_fault(irq_fault),
    .ss_out_n(ss_out_n), .ss_oe(ss_oe)
  );

  spi_rate_div #(.PRE_W(3), .EXP_W(3)) u_div (
    .clk(clk), .rst_n(core_rst_n), .run(busy),
    .pre(pre), .expo(expo), .tick(tick)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(core_rst_n), .start(start), .abort(abort),
    .tx_byte(bus_wdata), .pol(mode.pol), .pha(mode.pha),
    .lsb_first(mode.lsb_first), .tick(tick), .miso(miso),
    .busy(busy), .sck(sck), .mosi(mosi), .done(done), .rx_byte(rx_byte)
  );
endmodule

// File: tb/spi_byte_master_test.sv
`timescale 1ns/1ps
module spi_byte_master_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr, bus_rd;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq_done, irq_fault, sck, mosi, miso, ss_out_n, ss_oe, ss_in_n;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  spi_byte_master uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_done(irq_done), .irq_fault(irq_fault), .sck(sck), .mosi(mosi), .miso(miso),
    .ss_out_n(ss_out_n), .ss_oe(ss_oe), .ss_in_n(ss_in_n)
  );

  localparam logic [4:0] A_MODE = 5'h00, A_MODE2 = 5'h01, A_RATE = 5'h04, A_STAT = 5'h05,
                         A_DATA = 5'h09, A_PIN = 5'h0D, A_DIR = 5'h10;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  // slave model and scoreboard
  logic [7:0] exp_q[$];
  logic [7:0] s_tx, s_cap;
  bit         s_pol, s_pha, s_lsb, s_active;
  int         s_k;
  longint     s_t0, s_t2;

  function automatic logic sbit(input logic [7:0] b, input int i, input bit lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  always @(sck) begin
    if (s_active) begin
      automatic bit lead = (sck != s_pol);
      automatic int kk   = s_k / 2;
      if (s_k == 0) s_t0 = $time;
      if (s_k == 2) s_t2 = $time;
      if (s_pha ? !lead : lead) begin
        s_cap[s_lsb ? kk : 7 - kk] = mosi;
      end else if (s_pha) begin
        miso = sbit(s_tx, kk, s_lsb);
      end else if (kk < 7) begin
        miso = sbit(s_tx, kk + 1, s_lsb);
      end
      s_k++;
      if (s_k == 16) begin
        automatic logic [7:0] e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        chk(s_cap === e, "R4/R5 MOSI stream", s_cap, e);
        s_active = 0;
      end
    end
  end

  task automatic arm_slave(input bit pol, input bit pha, input bit lsb,
                           input logic [7:0] stx, input logic [7:0] mtx);
    s_pol = pol; s_pha = pha; s_lsb = lsb; s_tx = stx; s_k = 0;
    miso = pha ? 1'b0 : sbit(stx, 0, lsb);
    exp_q.push_back(mtx);
    s_active = 1;
  endtask

  task automatic wait_done(output bit ok);
    logic [7:0] st;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      rd(A_STAT, st);
      if (st[7]) begin ok = 1; break; end
    end
  endtask

  task automatic xfer(input bit pol, input bit pha, input bit lsb, input logic [7:0] rate,
                      input logic [7:0] mtx, input logic [7:0] stx);
    logic [7:0] d;
    bit ok;
    int per, eper;
    wr(A_RATE, rate);
    wr(A_MODE, {1'b1, 1'b1, 1'b0, 1'b1, pol, pha, 1'b0, lsb});
    #1 chk(sck == pol, "R3 idle level", sck, pol);
    arm_slave(pol, pha, lsb, stx, mtx);
    wr(A_DATA, mtx);
    wait_done(ok);
    chk(ok, "R2 completion flag", ok, 1);
    chk(irq_done == 1'b1, "R10 irq_done", irq_done, 1);
    chk(sck == pol, "R3 level after shift", sck, pol);
    rd(A_DATA, d);
    chk(d == stx, "R2/R4/R5 received byte", d, stx);
    per  = int'((s_t2 - s_t0) / 5);
    eper = (int'(rate[6:4]) + 1) * (2 << rate[2:0]);
    chk(per == eper, "R6 SCK period", per, eper);
    rd(A_STAT, d);
    chk(d == 8'h00, "R8 flags cleared", d, 0);
  endtask

  initial begin
    #(150000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit ok;
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    miso = 0; ss_in_n = 1; s_active = 0; s_k = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(A_MODE, d);   chk(d == 8'h00, "R1 mode", d, 0);
    rd(A_MODE2, d);  chk(d == 8'h00, "R1 mode2", d, 0);
    rd(A_RATE, d);   chk(d == 8'h00, "R1 rate", d, 0);
    rd(A_STAT, d);   chk(d == 8'h00, "R1 status", d, 0);
    rd(A_PIN, d);    chk(d == 8'h08, "R1 pin data", d, 8'h08);
    rd(A_DIR, d);    chk(d == 8'h00, "R1 pin dir", d, 0);
    chk(sck == 0 && ss_out_n == 1 && ss_oe == 0, "R1 pins", {sck, ss_out_n, ss_oe}, 3'b010);

    // R11 slave-select pin
    wr(A_DIR, 8'h0E);
    chk(ss_oe == 1, "R11 driver on", ss_oe, 1);
    wr(A_PIN, 8'h00);
    chk(ss_out_n == 0, "R11 select asserted", ss_out_n, 0);

    // R12 no shift when not enabled master
    wr(A_MODE, 8'h10);
    wr(A_DATA, 8'hA5);
    repeat (40) @(negedge clk);
    rd(A_STAT, d);
    chk(d == 8'h00 && sck == 0, "R12 master only", d, 0);
    wr(A_MODE, 8'h40);
    wr(A_DATA, 8'hA5);
    repeat (40) @(negedge clk);
    rd(A_STAT, d);
    chk(d == 8'h00 && sck == 0, "R12 enable only", d, 0);

    // R2-R6 all modes, orders and rates
    xfer(0, 0, 0, 8'h00, 8'hA5, 8'h3C);
    xfer(0, 1, 0, 8'h21, 8'h5A, 8'hC3);
    xfer(1, 0, 1, 8'h13, 8'h81, 8'h7E);
    xfer(1, 1, 1, 8'h70, 8'h1F, 8'hE0);
    xfer(0, 0, 1, 8'h01, 8'h96, 8'h69);
    xfer(1, 1, 0, 8'h12, 8'h0F, 8'hF1);

    // R7 collision, R8 clear ordering
    wr(A_RATE, 8'h13);
    wr(A_MODE, 8'hD0);
    arm_slave(0, 0, 0, 8'h55, 8'hC6);
    wr(A_DATA, 8'hC6);
    wr(A_DATA, 8'hFF);
    for (int i = 0; i < 2000 && !irq_done; i++) @(negedge clk);
    chk(irq_done == 1, "R10 completion interrupt", irq_done, 1);
    chk(exp_q.size() == 0 && !s_active, "R7 only first byte sent", exp_q.size(), 0);
    rd(A_DATA, d);
    chk(d == 8'h55, "R7 received byte intact", d, 8'h55);
    rd(A_STAT, d);
    chk(d == 8'hC0, "R8 flags survive unqualified data read", d, 8'hC0);
    rd(A_DATA, d);
    rd(A_STAT, d);
    chk(d == 8'h00, "R8 status then data clears", d, 0);
    repeat (100) @(negedge clk);
    chk(sck == 0, "R7 dropped byte not shifted", sck, 0);

    // R9 mode fault
    wr(A_DIR, 8'h00);
    ss_in_n = 0;
    @(negedge clk);
    ss_in_n = 1;
    @(negedge clk);
    rd(A_STAT, d);
    chk(d == 8'h10, "R9 fault flag", d, 8'h10);
    chk(irq_fault == 1, "R10 fault interrupt", irq_fault, 1);
    rd(A_DATA, d);
    rd(A_STAT, d);
    chk(d == 8'h00 && irq_fault == 0, "R8 fault cleared", d, 0);

    // R10 interrupt masked by enable bit
    wr(A_DIR, 8'h0E);
    wr(A_MODE, 8'h50);
    arm_slave(0, 0, 0, 8'h12, 8'h34);
    wr(A_DATA, 8'h34);
    wait_done(ok);
    chk(ok && irq_done == 0, "R10 masked irq", irq_done, 0);
    rd(A_DATA, d);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule